// File: doc/BRIEF.md
# Boot Clock Source Detection Sequencer

This block runs once after reset and moves the system clock off the slow clock onto the main oscillator. It controls an oscillator block through an enable line, a bypass line and a start-up time field. It reads back three flags and one count from that block: main-clock ready, oscillator stable and master-clock ready, plus the measured main-clock frequency.

With the oscillator bypassed, the sequencer waits for the frequency measurement and reads the count. A large count means an external clock drives the input pin. In that case the bypass stays in place and the oscillator is never started. A small count means a crystal is attached. In that case the bypass is removed, the oscillator is enabled with the longest start-up time, and the sequencer waits for it to stabilize.

In both cases the master clock source then moves to the main oscillator with no prescaling, and the sequencer waits for master-clock ready before it raises a one-way done flag. Every wait has a timeout. When a wait expires, the block raises an error and leaves the master clock on the slow clock.

Top module: `boot_clk_seq`

## Requirements
- R1: While reset is applied, mck_src_o is 0 (slow clock), and osc_en_o, osc_bypass_o, src_valid_o, done_o and err_o are all 0.
- R2: On the first clock edge after reset is released, osc_bypass_o goes to 1 while osc_en_o stays 0.
- R3: The sequencer waits until main_rdy_i is 1. It samples main_freq_i on that same edge, and later values of main_freq_i have no effect on the outputs.
- R4: An unsigned sampled count greater than 16 sets src_ext_o to 1 (external clock). A count of 16 or less sets src_ext_o to 0 (crystal). src_valid_o rises on the same edge.
- R5: On the external-clock path, osc_bypass_o stays 1 and osc_en_o never goes to 1.
- R6: On the crystal path, one edge sets osc_bypass_o to 0, osc_en_o to 1 and osc_startup_o to 8'hFF. mck_src_o stays 0 until osc_stable_i has been seen as 1.
- R7: When the source is ready, mck_src_o goes to 1 with prescale_o at 0 (divide-by-1). done_o rises on the edge that samples mck_rdy_i as 1, and not before.
- R8: Once done_o is 1 it stays 1 until reset, whatever the inputs do.
- R9: When a polling wait lasts TIMEOUT_CYC cycles without its input, err_o rises, mck_src_o is 0 from then on, and done_o stays 0.
- R10: Once src_valid_o is 1, it and src_ext_o keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_rdy_i | input | 1 | Main-clock frequency measurement ready |
| main_freq_i | input | FREQ_W (16) | Measured main-clock count |
| osc_stable_i | input | 1 | Oscillator stabilized |
| mck_rdy_i | input | 1 | Master clock ready after source change |
| osc_en_o | output | 1 | Oscillator enable |
| osc_bypass_o | output | 1 | Oscillator bypass |
| osc_startup_o | output | STUP_W (8) | Oscillator start-up time |
| mck_src_o | output | 1 | Master clock source: 0 slow, 1 main |
| prescale_o | output | 3 | Master clock prescaler code, 0 = divide-by-1 |
| src_ext_o | output | 1 | Detected source: 1 external clock, 0 crystal |
| src_valid_o | output | 1 | src_ext_o holds a classification |
| done_o | output | 1 | Sequence complete, sticky |
| err_o | output | 1 | A polling wait timed out |

## Verification
The assertions check on every cycle the relations between the outputs:
- enable and bypass are never both set;
- the start-up field is at its maximum whenever the oscillator is enabled;
- the external path never enables the oscillator;
- done and the classification are sticky;
- done implies the main oscillator at divide-by-1;
- an error leaves the slow clock selected.

Other properties can only be shown by the bench scenarios, because they depend on what the environment does:
- where the threshold falls (16 against 17);
- that the count is sampled on the ready edge and ignored afterwards;
- that the switch waits for stabilization;
- that done waits for master-clock ready;
- the timeout in each of the three waits.

// File: rtl/boot_clk_pkg.sv
package boot_clk_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_POLL_MAIN,
    ST_POLL_STAB,
    ST_POLL_MCK,
    ST_DONE,
    ST_FAIL
  } boot_st_e;

  localparam int unsigned PRES_W = 3;
  localparam logic [PRES_W-1:0] PRES_DIV1 = '0;
endpackage

// File: rtl/boot_clk_poll_timer.sv
module boot_clk_poll_timer #(
  parameter int unsigned LIMIT = 1 << 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i)                  cnt_q <= '0;
    else if (run_i && (cnt_q != LAST))   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R9: counter never passes the limit
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i && (cnt_q == LAST) |=> (cnt_q == LAST) || !run_i);
endmodule

// File: rtl/boot_clk_classify.sv
module boot_clk_classify #(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned THRESH = 16
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic              is_ext_o
);
  localparam logic [FREQ_W-1:0] THRESH_V = FREQ_W'(THRESH);

  // unsigned compare; strictly above threshold means external clock
  assign is_ext_o = (freq_i > THRESH_V);
endmodule

// File: rtl/boot_clk_seq.sv
module boot_clk_seq
  import boot_clk_pkg::*;
#(
  parameter int unsigned FREQ_W      = 16,
  parameter int unsigned STUP_W      = 8,
  parameter int unsigned EXT_THRESH  = 16,
  parameter int unsigned TIMEOUT_CYC = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              main_rdy_i,
  input  logic [FREQ_W-1:0] main_freq_i,
  input  logic              osc_stable_i,
  input  logic              mck_rdy_i,
  output logic              osc_en_o,
  output logic              osc_bypass_o,
  output logic [STUP_W-1:0] osc_startup_o,
  output logic              mck_src_o,
  output logic [2:0]        prescale_o,
  output logic              src_ext_o,
  output logic              src_valid_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [STUP_W-1:0] STUP_MAX = '1;

  boot_st_e state_q, state_d;
  logic     is_ext, expired, polling, restart;

  boot_clk_classify #(.FREQ_W(FREQ_W), .THRESH(EXT_THRESH)) i_classify (
    .freq_i   (main_freq_i),
    .is_ext_o (is_ext)
  );

  assign polling = (state_q == ST_POLL_MAIN) || (state_q == ST_POLL_STAB) ||
                   (state_q == ST_POLL_MCK);
  assign restart = (state_d != state_q);

  boot_clk_poll_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (polling),
    .expired_o (expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START:     state_d = ST_POLL_MAIN;
      ST_POLL_MAIN: if (main_rdy_i)   state_d = is_ext ? ST_POLL_MCK : ST_POLL_STAB;
                    else if (expired) state_d = ST_FAIL;
      ST_POLL_STAB: if (osc_stable_i) state_d = ST_POLL_MCK;
                    else if (expired) state_d = ST_FAIL;
      ST_POLL_MCK:  if (mck_rdy_i)    state_d = ST_DONE;
                    else if (expired) state_d = ST_FAIL;
      default:      state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_START;
      osc_en_o      <= 1'b0;
      osc_bypass_o  <= 1'b0;
      osc_startup_o <= '0;
      mck_src_o     <= 1'b0;
      prescale_o    <= PRES_DIV1;
      src_ext_o     <= 1'b0;
      src_valid_o   <= 1'b0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_START: osc_bypass_o <= 1'b1;
        ST_POLL_MAIN: begin
          if (main_rdy_i) begin
            src_valid_o <= 1'b1;
            src_ext_o   <= is_ext;
            if (is_ext) begin
              mck_src_o  <= 1'b1;
              prescale_o <= PRES_DIV1;
            end else begin
              osc_bypass_o  <= 1'b0;
              osc_en_o      <= 1'b1;
              osc_startup_o <= STUP_MAX;
            end
          end else if (expired) begin
            err_o <= 1'b1;
          end
        end
        ST_POLL_STAB: begin
          if (osc_stable_i) begin
            mck_src_o  <= 1'b1;
            prescale_o <= PRES_DIV1;
          end else if (expired) begin
            err_o <= 1'b1;
          end
        end
        ST_POLL_MCK: begin
          if (mck_rdy_i) begin
            done_o <= 1'b1;
          end else if (expired) begin
            mck_src_o <= 1'b0;
            err_o     <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_en_no_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o |-> !osc_bypass_o);
  p_startup_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o |-> (osc_startup_o == STUP_MAX));
  p_ext_no_osc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o && src_ext_o |-> osc_bypass_o && !osc_en_o);
  p_done_main_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mck_src_o && (prescale_o == PRES_DIV1));
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_err_slow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mck_src_o && !done_o);
  p_src_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o |=> src_valid_o && $stable(src_ext_o));
endmodule

// File: tb/test_boot_clk_seq.sv
module test_boot_clk_seq;
  localparam int TMO = 64;

  typedef struct packed {
    logic done;
    logic err;
    logic ext;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        main_rdy_i = 1'b0;
  logic [15:0] main_freq_i = '0;
  logic        osc_stable_i = 1'b0;
  logic        mck_rdy_i = 1'b0;
  logic        osc_en_o, osc_bypass_o, mck_src_o, src_ext_o, src_valid_o, done_o, err_o;
  logic [7:0]  osc_startup_o;
  logic [2:0]  prescale_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  exp_t sb_q[$];
  logic seen = 1'b0;

  always #2 clk_i = ~clk_i;

  boot_clk_seq #(.TIMEOUT_CYC(TMO)) i_boot_clk_seq (
    .clk_i, .rst_ni, .main_rdy_i, .main_freq_i, .osc_stable_i, .mck_rdy_i,
    .osc_en_o, .osc_bypass_o, .osc_startup_o, .mck_src_o, .prescale_o,
    .src_ext_o, .src_valid_o, .done_o, .err_o
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
    end
  end

  // monitor: compares the final result of each run with the scoreboard
  always @(negedge clk_i) begin
    if (!rst_ni) seen = 1'b0;
    else if ((done_o || err_o) && !seen) begin
      seen = 1'b1;
      if (sb_q.size() == 0) chk(1'b0, "R7 scoreboard empty", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(done_o == e.done, "R7 done result", done_o, e.done);
        chk(err_o == e.err, "R9 err result", err_o, e.err);
        if (e.done) chk(src_ext_o == e.ext, "R4 source result", src_ext_o, e.ext);
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    main_rdy_i = 1'b0; osc_stable_i = 1'b0; mck_rdy_i = 1'b0; main_freq_i = '0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(!mck_src_o && !osc_en_o && !osc_bypass_o, "R1 reset clocks", {mck_src_o, osc_en_o, osc_bypass_o}, 0);
    chk(!src_valid_o && !done_o && !err_o, "R1 reset flags", {src_valid_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(osc_bypass_o && !osc_en_o, "R2 bypass first", {osc_bypass_o, osc_en_o}, 2);
  endtask

  task automatic run(input logic [15:0] freq, input int rdy_dly, input int stab_dly,
                     input int mck_dly, input logic ext);
    exp_t e;
    e.done = 1'b1; e.err = 1'b0; e.ext = ext;
    do_reset();
    sb_q.push_back(e);
    for (int i = 0; i < rdy_dly; i++) begin
      main_freq_i = 16'hFFFF - freq; // ignored while not ready
      @(negedge clk_i);
      chk(!src_valid_o && osc_bypass_o, "R3 waits ready", src_valid_o, 0);
    end
    main_freq_i = freq;
    main_rdy_i = 1'b1;
    @(negedge clk_i);
    main_rdy_i = 1'b0;
    main_freq_i = ext ? 16'd0 : 16'd500;
    chk(src_valid_o && src_ext_o == ext, "R4 classify", src_ext_o, ext);
    if (ext) begin
      chk(osc_bypass_o && !osc_en_o, "R5 ext keeps bypass", {osc_bypass_o, osc_en_o}, 2);
    end else begin
      chk(!osc_bypass_o && osc_en_o && osc_startup_o == 8'hFF, "R6 crystal start",
          osc_startup_o, 255);
      for (int i = 0; i < stab_dly; i++) begin
        @(negedge clk_i);
        chk(!mck_src_o, "R6 waits stable", mck_src_o, 0);
      end
      osc_stable_i = 1'b1;
      @(negedge clk_i);
    end
    chk(mck_src_o && prescale_o == 3'd0, "R7 switch main div1", {mck_src_o, prescale_o}, 8);
    for (int i = 0; i < mck_dly; i++) begin
      @(negedge clk_i);
      chk(!done_o, "R7 waits mck ready", done_o, 0);
      if (ext) chk(!osc_en_o, "R5 no osc start", osc_en_o, 0);
    end
    mck_rdy_i = 1'b1;
    @(negedge clk_i);
    chk(done_o, "R7 done", done_o, 1);
    mck_rdy_i = 1'b0; osc_stable_i = 1'b0; main_rdy_i = 1'b1;
    main_freq_i = ext ? 16'd1 : 16'hFFFF;
    repeat (5) @(negedge clk_i);
    chk(done_o && !err_o, "R8 done sticky", done_o, 1);
    chk(src_valid_o && src_ext_o == ext, "R10 source held", src_ext_o, ext);
    main_rdy_i = 1'b0;
  endtask

  // stage 0: no main ready, 1: no stable, 2: no master ready
  task automatic tmo_run(input int stage);
    exp_t e;
    int n;
    e.done = 1'b0; e.err = 1'b1; e.ext = 1'b0;
    do_reset();
    sb_q.push_back(e);
    if (stage > 0) begin
      main_freq_i = (stage == 1) ? 16'd5 : 16'd100;
      main_rdy_i = 1'b1;
      @(negedge clk_i);
      main_rdy_i = 1'b0;
    end
    n = 0;
    while (!err_o && n < TMO + 10) begin
      @(negedge clk_i);
      n++;
    end
    chk(err_o && n >= TMO - 2 && n <= TMO + 2, "R9 timeout window", n, TMO);
    chk(!mck_src_o && !done_o, "R9 slow clock kept", mck_src_o, 0);
    mck_rdy_i = 1'b1; osc_stable_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!done_o && err_o && !mck_src_o, "R9 error final", done_o, 0);
  endtask

  initial begin
    run(16'd17, 3, 0, 2, 1'b1);     // just above threshold
    run(16'd16, 0, 4, 0, 1'b0);     // exactly threshold -> crystal
    run(16'd0, 5, 1, 3, 1'b0);
    run(16'hFFFF, 1, 0, 0, 1'b1);   // top of unsigned range
    run(16'h8000, 2, 0, 1, 1'b1);
    tmo_run(0);
    tmo_run(1);
    tmo_run(2);
    repeat (2) @(negedge clk_i);
    chk(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    summary();
  end
endmodule